// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block sits on the cartridge side of a tile-based video system and raises a CPU interrupt after a programmed number of rendered lines. It does not receive a line pulse. It watches bit 12 of the picture processor's pattern-memory address. Background patterns are fetched from the lower 4 KB half and sprite patterns from the upper half, so this bit rises once per rendered line. Each accepted rising edge clocks an 8-bit down-counter. When the counter is zero, it reloads from a latch that the CPU wrote.

The CPU controls the block through writes to the upper cartridge address range. These writes set the reload latch, request a forced reload, enable the interrupt, or disable it. Disabling the interrupt also acknowledges a pending one. The address line is synchronised and filtered. A rising edge counts only after the line has been low for a minimum number of clocks, so the short toggles inside one line are not counted. The interrupt output is active-low and level-sensitive. It stays asserted until the CPU acknowledges it.

Top module: `scanline_irq`

## Requirements
- R1: After reset, irq_no is high, the counter and the reload latch are zero, and the interrupt is disabled.
- R2: A write with wr_addr_i[15:13]=3'b110 and wr_addr_i[0]=0 stores wr_data_i in the reload latch.
- R3: On each counted edge, the counter loads the latch if it is zero or a reload is pending. Otherwise it decrements by one. It does not change between counted edges.
- R4: When a counted edge leaves the counter at zero and the interrupt is enabled, irq_no goes low. With latch N and a zero counter, this happens on the (N+1)th counted edge.
- R5: While the interrupt is disabled, reaching zero does not assert irq_no.
- R6: A write with wr_addr_i[15:13]=3'b111 and wr_addr_i[0]=0 disables the interrupt and releases irq_no to high. A write with wr_addr_i[0]=1 in that range enables the interrupt.
- R7: A write with wr_addr_i[15:13]=3'b110 and wr_addr_i[0]=1 makes the next counted edge load the latch, whatever the count is.
- R8: A rising edge of ppu_a12_i is counted only if the synchronised line was low for at least LOW_MIN (default 8) clocks before it.
- R9: Once asserted, irq_no stays low through further counted edges until a disable write.
- R10: Writes with wr_addr_i[15:14] other than 2'b11 have no effect.
- R11: With a latch of zero and the interrupt enabled, every counted edge asserts irq_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| ppu_a12_i | input | 1 | Snooped picture-processor address bit 12, asynchronous |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that every CPU write is a one-cycle strobe. They assume the snooped address line stays low for a full line's fetch window between real line edges. They do not assume that a reload request and a counted edge arrive apart. The stimulus drives each line as at least twelve low clocks followed by six high clocks, and drives one deliberately short low gap to test the filter. Writes are made only while ppu_a12_i is static, so no decision in the bench depends on a write and a counted edge landing in the same cycle.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  typedef struct packed {
    logic set_latch;
    logic req_reload;
    logic irq_off;
    logic irq_on;
  } ctl_cmd_t;

  function automatic ctl_cmd_t decode_wr(input logic we, input logic [15:0] addr);
    ctl_cmd_t c;
    c = '0;
    if (we && addr[15:13] == 3'b110) begin
      c.set_latch  = ~addr[0];
      c.req_reload = addr[0];
    end
    if (we && addr[15:13] == 3'b111) begin
      c.irq_off = ~addr[0];
      c.irq_on  = addr[0];
    end
    return c;
  endfunction
endpackage

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MIN     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a12_i,
  output logic edge_o
);
  localparam int LW = $clog2(LOW_MIN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   a12_q, a12_prev_q;
  logic [LW-1:0]          low_cnt_q;

  assign a12_q = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      a12_prev_q <= 1'b0;
      low_cnt_q  <= '0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], a12_i};
      a12_prev_q <= a12_q;
      if (a12_q)                       low_cnt_q <= '0;
      else if (low_cnt_q != LW'(LOW_MIN)) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  // qualified rise: line held low long enough beforehand
  assign edge_o = a12_q & ~a12_prev_q & (low_cnt_q == LW'(LOW_MIN));

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
  assert_edge_after_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> a12_prev_q);
endmodule

// File: rtl/line_counter.sv
module line_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             latch_we_i,
  input  logic [CNT_W-1:0] latch_d_i,
  input  logic             reload_req_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, latch_q, cnt_d;
  logic             reload_pend_q;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = (cnt_q == '0 || reload_pend_q) ? latch_q : cnt_q - 1'b1;
  end

  assign hit_o = tick_i && (cnt_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= '0;
      latch_q       <= '0;
      reload_pend_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (latch_we_i)        latch_q <= latch_d_i;
      if (reload_req_i)      reload_pend_q <= 1'b1;
      else if (tick_i)       reload_pend_q <= 1'b0;
    end
  end

  assert_latch_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_we_i |=> latch_q == $past(latch_d_i));
  assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !reload_pend_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_forced_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && reload_pend_q) |=> cnt_q == $past(latch_q));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic irq_on_i,
  input  logic irq_off_i,
  output logic irq_no
);
  logic enable_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (irq_off_i) begin
      enable_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (irq_on_i)          enable_q <= 1'b1;
      if (hit_i && enable_q) pend_q   <= 1'b1;
    end
  end

  assign irq_no = ~pend_q;

  assert_ack_releases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_off_i |=> irq_no);
  assert_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !irq_off_i) |=> !irq_no);
  assert_disabled_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_q && irq_no) |=> irq_no);
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int CNT_W       = 8,
  parameter int LOW_MIN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [15:0]      wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ppu_a12_i,
  output logic             irq_no
);
  import scanline_irq_pkg::*;

  ctl_cmd_t cmd;
  logic     tick, hit;

  assign cmd = decode_wr(wr_en_i, wr_addr_i);

  a12_edge_filter #(.SYNC_STAGES(SYNC_STAGES), .LOW_MIN(LOW_MIN)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .a12_i(ppu_a12_i), .edge_o(tick));

  line_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .latch_we_i(cmd.set_latch), .latch_d_i(wr_data_i),
    .reload_req_i(cmd.req_reload), .hit_o(hit));

  irq_ctrl u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit),
    .irq_on_i(cmd.irq_on), .irq_off_i(cmd.irq_off), .irq_no(irq_no));

  assert_low_addr_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[15:14] != 2'b11) |-> cmd == '0);
endmodule

// File: tb/scanline_irq_bench.sv
module scanline_irq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        a12 = 1'b0;
  logic        irq_n;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  scanline_irq u_scanline_irq (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ppu_a12_i(a12), .irq_no(irq_n));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s irq_no actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic line(input int low_cyc);
    a12 = 1'b0;
    repeat (low_cyc) @(negedge clk);
    a12 = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) line(12);
  endtask

  task automatic t_reset;
    chk(irq_n, 1'b1, "R1 reset");
  endtask

  task automatic t_basic;  // count 0 -> irq on 4th edge with latch 3
    wr(16'hC000, 8'd3); wr(16'hE001, 8'd0);
    lines(3); chk(irq_n, 1'b1, "R2 R3 before zero");
    lines(1); chk(irq_n, 1'b0, "R4 zero asserts");
  endtask

  task automatic t_hold;  // count 0 -> edge reloads 3
    lines(1); chk(irq_n, 1'b0, "R9 held");
    wr(16'hE000, 8'd0); chk(irq_n, 1'b1, "R6 ack");
    wr(16'hE001, 8'd0);
    lines(2); chk(irq_n, 1'b1, "R3 decrementing");
    lines(1); chk(irq_n, 1'b0, "R4 second period");
  endtask

  task automatic t_disabled;
    wr(16'hE000, 8'd0);
    lines(4); chk(irq_n, 1'b1, "R5 disabled at zero");
  endtask

  task automatic t_reload;  // count 0
    wr(16'hE001, 8'd0); wr(16'hC000, 8'd5);
    lines(2);               // load 5, then 4
    wr(16'hC001, 8'd0);
    lines(5); chk(irq_n, 1'b1, "R7 forced reload");
    lines(1); chk(irq_n, 1'b0, "R7 zero after reload");
  endtask

  task automatic t_glitch;  // count 0
    wr(16'hE000, 8'd0); wr(16'hC000, 8'd1); wr(16'hE001, 8'd0);
    lines(1);               // load 1
    line(3); chk(irq_n, 1'b1, "R8 short gap ignored");
    lines(1); chk(irq_n, 1'b0, "R8 real edge counted");
  endtask

  task automatic t_ignore;  // count 0
    wr(16'hE000, 8'd0); wr(16'hC000, 8'd2); wr(16'hE001, 8'd0);
    wr(16'h8000, 8'd0); wr(16'hA000, 8'd0); wr(16'h6001, 8'd0);
    wr(16'h4000, 8'd0);
    lines(2); chk(irq_n, 1'b1, "R10 latch kept");
    lines(1); chk(irq_n, 1'b0, "R10 zero at latch 2");
    wr(16'hE000, 8'd0); wr(16'h6001, 8'd0); wr(16'h4001, 8'd0);
    lines(3); chk(irq_n, 1'b1, "R10 enable not set by low write");
  endtask

  task automatic t_zero_latch;  // count 0
    wr(16'hC000, 8'd0); wr(16'hE001, 8'd0);
    lines(1); chk(irq_n, 1'b0, "R11 first edge");
    wr(16'hE000, 8'd0); wr(16'hE001, 8'd0); chk(irq_n, 1'b1, "R6 re-ack");
    lines(1); chk(irq_n, 1'b0, "R11 next edge");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (12) @(negedge clk);
    t_reset;
    t_basic;
    t_hold;
    t_disabled;
    t_reload;
    t_glitch;
    t_ignore;
    t_zero_latch;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule